// File: doc/BRIEF.md
# Block-Cipher Command Front-End

This unit sits between an 8-bit special-function-register bus and a 128-bit block-cipher engine. Software or a DMA channel controls it through three byte registers: a control/status register, an input byte register and an output byte register. A single write to the control register picks the chaining mode and the operation, and a start bit launches the operation. The operation is one of load key, load IV/nonce, encrypt block or decrypt block. The unit then gathers sixteen input bytes into a 128-bit word, hands that word to the engine with a one-cycle start strobe, and waits for the engine's done strobe. After an encrypt or decrypt it hands the sixteen result bytes back one at a time.

The byte bus has no wait states, so there is no back-pressure on it. Flow control comes from two request lines. The input request stays high while the unit can accept another input byte. The output request stays high while a result byte is waiting to be read. A write or read made outside these windows does not advance the transfer. The engine port is a plain start/done handshake. The unit holds the word, command and mode steady from start until done. The cipher rounds and the chaining arithmetic belong to the engine. This unit only carries the mode field to it.

A low-power-exit pulse returns every register to its reset value, the same as a full reset.

Top module: `cipher_ctl_front`

## Requirements
- R1: After reset, the control register (address 0) reads 0x08, the input register (address 1) and the output register (address 2) read 0x00, and both DMA requests and `eng_start` are low.
- R2: Control bits 6:4 hold the mode (000 CBC, 001 CFB, 010 OFB, 011 CTR, 100 ECB, 101 CBC-MAC, 110/111 reserved), which is readable and driven on `eng_mode`. Bit 7 always reads 0.
- R3: Control bits 2:1 hold the command (00 encrypt, 01 decrypt, 10 load key, 11 load IV/nonce), which is readable and driven on `eng_cmd`. Neither field changes while the unit is busy.
- R4: Writing 1 to control bit 0 while idle starts the command. Bit 0 reads 1 during the cycle after that write and 0 otherwise. A control write with bit 0 = 0 starts nothing.
- R5: Control bit 3 (ready) reads 0 from the cycle after an accepted start until the operation completes, and reads 1 otherwise.
- R6: `dma_in_req` is high while fewer than 16 input bytes of the block have been written. The first byte written lands in `eng_din[127:120]` and the sixteenth in `eng_din[7:0]`.
- R7: `eng_start` pulses for exactly one cycle, in the cycle after the sixteenth input byte is written.
- R8: For encrypt and decrypt, `eng_done` captures `eng_dout`. `dma_out_req` then stays high while the 16 result bytes are read from address 2, most significant byte first, and ready returns once the last byte is read.
- R9: For key and IV loads, ready returns in the cycle after `eng_done`, and `dma_out_req` stays low.
- R10: A start write made while ready is 0 is ignored. Mode, command, byte count and ready are left unchanged.
- R11: A write to the input register while `dma_in_req` is low is dropped. The register keeps its old value.
- R12: A one-cycle `lp_exit` pulse puts every register back to its reset value. This abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_exit | input | 1 | Synchronous return-to-reset pulse on exit from deep sleep |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 2 consumes a result byte |
| bus_addr | input | 2 | Register select: 0 control, 1 input, 2 output |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from register state) |
| dma_in_req | output | 1 | Input byte wanted |
| dma_out_req | output | 1 | Output byte available |
| eng_start | output | 1 | One-cycle start to the cipher engine |
| eng_cmd | output | 2 | Operation for the engine |
| eng_mode | output | 3 | Chaining mode for the engine |
| eng_din | output | 128 | Assembled input block |
| eng_done | input | 1 | Engine finished (one-cycle strobe) |
| eng_dout | input | 128 | Engine result, valid with `eng_done` |

## Verification
Read data is combinational, so the value read at an address reflects every register update up to the last clock edge. Each bus access in the bench is driven on a falling edge and sampled just before the next rising edge. As a result, the start flag and the cleared ready bit are checked on the read that immediately follows the start write. `eng_start` is checked in the cycle after the sixteenth byte write, and checked low one cycle later. `dma_out_req` and ready are checked in the cycle after `eng_done`. Every result byte is compared on the read that consumes it, and ready is checked on the cycle after the last read.

// File: rtl/cipher_ctl_pkg.sv
package cipher_ctl_pkg;

  typedef enum logic [1:0] {
    CMD_ENC = 2'b00,
    CMD_DEC = 2'b01,
    CMD_KEY = 2'b10,
    CMD_IV  = 2'b11
  } cipher_cmd_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_COLLECT,
    SEQ_RUN,
    SEQ_WAIT,
    SEQ_DRAIN
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIN  = 2'd1;
  localparam logic [1:0] ADDR_DOUT = 2'd2;

endpackage

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_exit,
  input  logic       wr_ctrl,
  input  logic [2:0] wmode,
  input  logic [1:0] wcmd,
  input  logic       wstart,
  input  logic       idle,
  output logic [2:0] mode,
  output logic [1:0] cmd,
  output logic       start_acc,
  output logic       st_flag
);

  logic accept;

  // Control writes are only taken while idle, so the engine sees steady fields.
  assign accept    = wr_ctrl && idle;
  assign start_acc = accept && wstart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      cmd     <= '0;
      st_flag <= 1'b0;
    end else if (lp_exit) begin
      mode    <= '0;
      cmd     <= '0;
      st_flag <= 1'b0;
    end else begin
      if (accept) begin
        mode <= wmode;
        cmd  <= wcmd;
      end
      st_flag <= start_acc;
    end
  end

endmodule

// File: rtl/cipher_byte_shift.sv
module cipher_byte_shift #(
  parameter  int DATA_W = 8,
  parameter  int BYTES  = 16,
  localparam int BLK_W  = DATA_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  output logic [BLK_W-1:0]  q
);

  // Lane 0 takes the new byte, each higher lane takes its lower neighbour,
  // so the earliest byte ends up in the top lane.
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_d;
    if (g == 0) begin : g_first
      assign lane_d = din;
    end else begin : g_rest
      assign lane_d = q[(g-1)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g*DATA_W +: DATA_W] <= '0;
      end else if (clr) begin
        q[g*DATA_W +: DATA_W] <= '0;
      end else if (shift_en) begin
        q[g*DATA_W +: DATA_W] <= lane_d;
      end
    end
  end

endmodule

// File: rtl/cipher_ctl_seq.sv
module cipher_ctl_seq
  import cipher_ctl_pkg::*;
#(
  parameter  int BYTES = 16,
  localparam int CNT_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_exit,
  input  logic             start_acc,
  input  logic [1:0]       cmd,
  input  logic             in_wr,
  input  logic             out_rd,
  input  logic             eng_done,
  output logic             idle,
  output logic             collecting,
  output logic             draining,
  output logic             eng_start,
  output logic             take_in,
  output logic             take_out,
  output logic             load_out,
  output logic [CNT_W-1:0] cnt
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             last, data_cmd;

  assign last     = (cnt == CNT_W'(BYTES - 1));
  assign data_cmd = (cmd == CMD_ENC) || (cmd == CMD_DEC);

  assign idle       = (state_q == SEQ_IDLE);
  assign collecting = (state_q == SEQ_COLLECT);
  assign draining   = (state_q == SEQ_DRAIN);
  assign eng_start  = (state_q == SEQ_RUN);
  assign take_in    = collecting && in_wr;
  assign take_out   = draining && out_rd;
  assign load_out   = (state_q == SEQ_WAIT) && eng_done && data_cmd;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_acc) begin
          state_d = SEQ_COLLECT;
          cnt_d   = '0;
        end
      end
      SEQ_COLLECT: begin
        if (in_wr) begin
          cnt_d = cnt + CNT_W'(1);
          if (last) begin
            state_d = SEQ_RUN;
            cnt_d   = '0;
          end
        end
      end
      SEQ_RUN: state_d = SEQ_WAIT;
      SEQ_WAIT: begin
        if (eng_done) begin
          state_d = data_cmd ? SEQ_DRAIN : SEQ_IDLE;
          cnt_d   = '0;
        end
      end
      SEQ_DRAIN: begin
        if (out_rd) begin
          cnt_d = cnt + CNT_W'(1);
          if (last) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt     <= '0;
    end else if (lp_exit) begin
      state_q <= SEQ_IDLE;
      cnt     <= '0;
    end else begin
      state_q <= state_d;
      cnt     <= cnt_d;
    end
  end

endmodule

// File: rtl/cipher_ctl_front.sv
module cipher_ctl_front
  import cipher_ctl_pkg::*;
#(
  parameter  int BYTES  = 16,
  localparam int DATA_W = 8,
  localparam int BLK_W  = DATA_W * BYTES,
  localparam int CNT_W  = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_exit,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_in_req,
  output logic              dma_out_req,
  output logic              eng_start,
  output logic [1:0]        eng_cmd,
  output logic [2:0]        eng_mode,
  output logic [BLK_W-1:0]  eng_din,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_dout
);

  logic              wr_ctrl, in_wr, out_rd;
  logic [2:0]        mode;
  logic [1:0]        cmd;
  logic              start_acc, st_flag;
  logic              ready, collecting, draining;
  logic              take_in, take_out, load_out;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] din_q, out_byte;
  logic [BLK_W-1:0]  out_blk;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign in_wr   = bus_wr && (bus_addr == ADDR_DIN);
  assign out_rd  = bus_rd && (bus_addr == ADDR_DOUT);

  cipher_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_exit   (lp_exit),
    .wr_ctrl   (wr_ctrl),
    .wmode     (bus_wdata[6:4]),
    .wcmd      (bus_wdata[2:1]),
    .wstart    (bus_wdata[0]),
    .idle      (ready),
    .mode      (mode),
    .cmd       (cmd),
    .start_acc (start_acc),
    .st_flag   (st_flag)
  );

  cipher_ctl_seq #(.BYTES(BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_exit    (lp_exit),
    .start_acc  (start_acc),
    .cmd        (cmd),
    .in_wr      (in_wr),
    .out_rd     (out_rd),
    .eng_done   (eng_done),
    .idle       (ready),
    .collecting (collecting),
    .draining   (draining),
    .eng_start  (eng_start),
    .take_in    (take_in),
    .take_out   (take_out),
    .load_out   (load_out),
    .cnt        (cnt)
  );

  cipher_byte_shift #(.DATA_W(DATA_W), .BYTES(BYTES)) u_in_blk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (lp_exit),
    .shift_en (take_in),
    .din      (bus_wdata),
    .q        (eng_din)
  );

  // Last accepted input byte, readable back at the input address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        din_q <= '0;
    else if (lp_exit)  din_q <= '0;
    else if (take_in)  din_q <= bus_wdata;
  end

  // Result block, held while the bytes are streamed out by pointer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_blk <= '0;
    else if (lp_exit)  out_blk <= '0;
    else if (load_out) out_blk <= eng_dout;
  end

  always_comb begin
    out_byte = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (cnt == CNT_W'(BYTES - 1 - i)) out_byte = out_blk[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {1'b0, mode, ready, cmd, st_flag};
      ADDR_DIN:  bus_rdata = din_q;
      ADDR_DOUT: bus_rdata = draining ? out_byte : '0;
      default:   bus_rdata = '0;
    endcase
  end

  assign dma_in_req  = collecting;
  assign dma_out_req = draining;
  assign eng_cmd     = cmd;
  assign eng_mode    = mode;

  // take_out only advances the pointer inside the sequencer.
  logic unused_ok;
  assign unused_ok = take_out;

endmodule

// File: rtl/cipher_ctl_chk.sv
module cipher_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_exit,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       ready,
  input logic       dma_in_req,
  input logic       dma_out_req,
  input logic       eng_start,
  input logic [1:0] eng_cmd,
  input logic [2:0] eng_mode,
  input logic [7:0] din_q
);

  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |-> !bus_rdata[7]);

  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !lp_exit) |=> ($stable(eng_cmd) && $stable(eng_mode)));

  assert_busy_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !ready);

  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_in_req && dma_out_req));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_din_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !dma_in_req && !lp_exit) |=> $stable(din_q));

  assert_lp_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |=> (ready && !dma_in_req && !dma_out_req && !eng_start));

endmodule

bind cipher_ctl_front cipher_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lp_exit     (lp_exit),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .ready       (ready),
  .dma_in_req  (dma_in_req),
  .dma_out_req (dma_out_req),
  .eng_start   (eng_start),
  .eng_cmd     (eng_cmd),
  .eng_mode    (eng_mode),
  .din_q       (din_q)
);

// File: tb/tb_cipher_ctl_front.sv
`timescale 1ns/1ps
module tb_cipher_ctl_front;

  logic         clk = 1'b0;
  logic         rst_n, lp_exit, bus_wr, bus_rd, eng_done;
  logic [1:0]   bus_addr;
  logic [7:0]   bus_wdata, bus_rdata;
  logic         dma_in_req, dma_out_req, eng_start;
  logic [1:0]   eng_cmd;
  logic [2:0]   eng_mode;
  logic [127:0] eng_din, eng_dout;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  cipher_ctl_front dut (
    .clk(clk), .rst_n(rst_n), .lp_exit(lp_exit),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
    .eng_start(eng_start), .eng_cmd(eng_cmd), .eng_mode(eng_mode),
    .eng_din(eng_din), .eng_done(eng_done), .eng_dout(eng_dout)
  );

  // {cmd[1:0], mode[2:0], seed[7:0]}
  localparam int NV = 5;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 3'b100, 8'h10},   // encrypt, ECB
    {2'b01, 3'b000, 8'h40},   // decrypt, CBC
    {2'b10, 3'b000, 8'h80},   // load key
    {2'b11, 3'b011, 8'h20},   // load IV, CTR
    {2'b00, 3'b101, 8'hF8}    // encrypt, CBC-MAC, seed wraps
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge.
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [127:0] stub_mask(input logic [1:0] c);
    return (c == 2'b01) ? {16{8'h3C}} : {16{8'hC3}};
  endfunction

  // Runs one full command; at byte index inj a busy start write is injected (R10).
  task automatic run_block(input logic [1:0] c, input logic [2:0] m, input logic [7:0] seed, input int inj);
    logic [7:0]   r, b;
    logic [127:0] blk, res;
    blk = '0;
    bus_write(2'd0, {1'b0, m, 1'b0, c, 1'b1});
    bus_read(2'd0, r);
    check("R4 start flag and R5 ready low after start", r, {1'b0, m, 1'b0, c, 1'b1});
    check("R6 input request raised", dma_in_req, 1'b1);
    for (int i = 0; i < 16; i++) begin
      if (i == inj) begin
        bus_write(2'd0, 8'h25);
        bus_read(2'd0, r);
        check("R10 busy start ignored", r, {1'b0, m, 1'b0, c, 1'b0});
        check("R10 still collecting", dma_in_req, 1'b1);
      end
      b   = seed + 8'(i);
      blk = {blk[119:0], b};
      check("R6 input request while collecting", dma_in_req, 1'b1);
      bus_write(2'd1, b);
    end
    check("R7 engine start after 16th byte", eng_start, 1'b1);
    check("R6 block order", eng_din, blk);
    check("R3 command to engine", eng_cmd, c);
    check("R2 mode to engine", eng_mode, m);
    check("R6 input request drops", dma_in_req, 1'b0);
    @(negedge clk);
    check("R7 engine start single cycle", eng_start, 1'b0);
    @(negedge clk);
    res      = blk ^ stub_mask(c);
    eng_dout = eng_din ^ stub_mask(c);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    eng_dout = '0;
    if (c[1] == 1'b0) begin
      for (int i = 0; i < 16; i++) begin
        check("R8 output request", dma_out_req, 1'b1);
        bus_read(2'd2, r);
        check("R8 result byte", r, res[127-8*i -: 8]);
      end
      check("R8 output request drops", dma_out_req, 1'b0);
      bus_read(2'd0, r);
      check("R8 ready after last read", r[3], 1'b1);
    end else begin
      check("R9 no output request on load", dma_out_req, 1'b0);
      bus_read(2'd0, r);
      check("R9 ready after load done", r[3], 1'b1);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; lp_exit = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; eng_done = 1'b0; eng_dout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, r); check("R1 control reset", r, 8'h08);
    bus_read(2'd1, r); check("R1 input reset", r, 8'h00);
    bus_read(2'd2, r); check("R1 output reset", r, 8'h00);
    check("R1 requests low", {dma_in_req, dma_out_req, eng_start}, 3'b000);

    // R11 input write while idle dropped
    bus_write(2'd1, 8'h5A);
    bus_read(2'd1, r); check("R11 idle input write dropped", r, 8'h00);
    check("R11 no input request", dma_in_req, 1'b0);

    // R2 bit 7 reads 0, reserved mode held; R4 no start when bit 0 = 0
    bus_write(2'd0, 8'hF6);
    bus_read(2'd0, r); check("R2 R3 fields stored, bit7 zero", r, 8'h7E);
    check("R4 no start without bit 0", dma_in_req, 1'b0);
    bus_read(2'd0, r); check("R5 ready stays high", r[3], 1'b1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      run_block(VEC[v][12:11], VEC[v][10:8], VEC[v][7:0], -1);
    end

    // R10 start write while busy
    run_block(2'b00, 3'b100, 8'h61, 5);

    // R12 low-power exit mid-block
    bus_write(2'd0, 8'h33);
    for (int i = 0; i < 3; i++) bus_write(2'd1, 8'hA0 + 8'(i));
    lp_exit = 1'b1;
    @(negedge clk);
    lp_exit = 1'b0;
    bus_read(2'd0, r); check("R12 control back to reset", r, 8'h08);
    bus_read(2'd1, r); check("R12 input back to reset", r, 8'h00);
    check("R12 requests cleared", {dma_in_req, dma_out_req}, 2'b00);
    run_block(2'b01, 3'b010, 8'hC0, -1);

    summary();
    $finish;
  end

endmodule